// File: doc/BRIEF.md
# Strided Vector Slice Address Generator

This block turns one strided vector memory request into eight slices of sixteen element addresses, one address per lane. A request is a byte base address, a signed stride counted in 8-byte elements, and a vector length of up to 128 elements. The elements are not issued in ascending order. A constant order table, selected by the power-of-two factor of the stride, groups the elements so that the sixteen addresses of each slice fall into sixteen different cache banks. This lets every lane read one 8-byte word in the same cycle.

The bank of an address is taken from the four bits just above the 64-byte line offset, which are address bits [9:6]. With 64-byte lines and sixteen banks, a conflict-free order exists whenever the stride's power-of-two exponent is 3 or less. A stride of zero, or a stride with a larger power-of-two factor, always conflicts with itself. Such a request is refused with an error pulse so that it can be sent to the conflict-resolution path.

A request always takes eight slice cycles, whatever its vector length. Elements at or beyond the vector length still appear in their slots, but with the lane enable cleared. A new request is taken only when no slices are being emitted.

Top module: `strided_slice_agen`

## Requirements
- R1: After reset, `busy`, `slice_vld`, `done` and `err` are all low.
- R2: A `start` with an accepted stride produces `slice_vld` for exactly 8 consecutive cycles, beginning the cycle after `start`, with `slice_idx` counting 0 to 7.
- R3: Each lane address equals base + element index × stride × 8, taken modulo 2^ADDR_W, with the stride sign-extended.
- R4: The 16 lane addresses of every slice differ in their bank bits [9:6].
- R5: Across the 8 slices of a request, every element index from 0 to 127 appears exactly once.
- R6: `lane_en` of a lane is 1 exactly when its element index is below `vlen`. A `vlen` above 128 enables all lanes. The request still runs all 8 slices when `vlen` is small, including when it is 0.
- R7: A stride of zero, or a stride with more than 3 trailing zero bits, raises `err` for one cycle, in the cycle after `start`. No slice is emitted for that request.
- R8: A `start` asserted while slices are being emitted is ignored, including during the eighth slice. The addresses of the running request are unchanged and no further slices follow.
- R9: `done` is high only during slice 7, and `slice_vld` is low in the cycle after it.
- R10: Within a slice, element indices increase strictly from lane 0 to lane 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when not busy |
| base | input | ADDR_W | Byte base address of element 0 |
| stride | input | STR_W | Signed stride in 8-byte elements |
| vlen | input | EL_W+1 | Vector length, 0 to 128 (larger means 128) |
| busy | output | 1 | Slices are being emitted |
| slice_vld | output | 1 | Current slice outputs are valid |
| slice_idx | output | SL_W | Number of the current slice, 0 to 7 |
| done | output | 1 | High with the last slice |
| err | output | 1 | One-cycle pulse: stride needs conflict resolution |
| lane_addr | output | LANES*ADDR_W | Byte address per lane, lane 0 in the low bits |
| lane_elem | output | LANES*EL_W | Element index per lane |
| lane_en | output | LANES | Per-lane valid bit |

## Verification
A bad entry in the order table shows at the ports within the same request. It produces either a repeated bank inside one slice or an element that is missing or repeated across the eight slices. The bench checks both on every slice, for odd strides, for each power-of-two factor up to 3, and for negative and wrapping addresses. An error in the slice counter or the accept logic shows within one cycle as a wrong `slice_idx`, a misplaced `done`, or a slice that appears after the eighth. A broken stride classifier shows in the cycle after `start` as a missing or spurious `err`.

// File: rtl/strided_slice_agen.sv
module strided_slice_agen #(
  parameter int ADDR_W  = 40,
  parameter int STR_W   = 20,
  parameter int LANES   = 16,
  parameter int SLICES  = 8,
  parameter int LINE_LG = 6
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  input  logic [ADDR_W-1:0]                     base,
  input  logic [STR_W-1:0]                      stride,
  input  logic [$clog2(LANES*SLICES):0]         vlen,
  output logic                                  busy,
  output logic                                  slice_vld,
  output logic [$clog2(SLICES)-1:0]             slice_idx,
  output logic                                  done,
  output logic                                  err,
  output logic [LANES*ADDR_W-1:0]               lane_addr,
  output logic [LANES*$clog2(LANES*SLICES)-1:0] lane_elem,
  output logic [LANES-1:0]                      lane_en
);
  localparam int ELEMS  = LANES * SLICES;
  localparam int EL_W   = $clog2(ELEMS);
  localparam int SL_W   = $clog2(SLICES);
  localparam int BANK_W = $clog2(LANES);
  localparam int MAX_S  = $clog2(SLICES);
  localparam int S_W    = $clog2(MAX_S + 1);
  localparam int ROM_N  = (MAX_S + 1) * SLICES;

  function automatic int first_elem(int s, int t);
    int d;
    d = 1 << (MAX_S - s);
    return (t >> (MAX_S - s)) * LANES * d + (t & (d - 1));
  endfunction

  function automatic int trail_z(logic [STR_W-1:0] v);
    int r;
    r = STR_W;
    for (int i = STR_W - 1; i >= 0; i--)
      if (v[i]) r = i;
    return r;
  endfunction

  logic [EL_W-1:0] order_rom [ROM_N];
  for (genvar gs = 0; gs <= MAX_S; gs++) begin : g_rom_s
    for (genvar gt = 0; gt < SLICES; gt++) begin : g_rom_t
      assign order_rom[gs*SLICES+gt] = EL_W'(first_elem(gs, gt));
    end
  end

  logic [ADDR_W-1:0] base_q;
  logic [STR_W-1:0]  stride_q;
  logic [EL_W:0]     vlen_q;
  logic [S_W-1:0]    pow_q;
  logic [SL_W-1:0]   cnt;
  logic              run;
  logic              err_q;

  int  tz;
  logic bad_stride;
  assign tz         = trail_z(stride);
  assign bad_stride = tz > MAX_S;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      cnt      <= '0;
      err_q    <= 1'b0;
      base_q   <= '0;
      stride_q <= '0;
      vlen_q   <= '0;
      pow_q    <= '0;
    end else begin
      err_q <= 1'b0;
      if (run) begin
        cnt <= cnt + SL_W'(1);
        if (cnt == SL_W'(SLICES - 1)) run <= 1'b0;
      end else if (start) begin
        if (bad_stride) begin
          err_q <= 1'b1;
        end else begin
          run      <= 1'b1;
          cnt      <= '0;
          base_q   <= base;
          stride_q <= stride;
          vlen_q   <= vlen;
          pow_q    <= S_W'(tz);
        end
      end
    end
  end

  assign busy      = run;
  assign slice_vld = run;
  assign slice_idx = cnt;
  assign done      = run && (cnt == SL_W'(SLICES - 1));
  assign err       = err_q;

  logic [EL_W-1:0]   first;
  logic [ADDR_W-1:0] stride_x;
  assign first    = order_rom[{pow_q, cnt}];
  assign stride_x = {{(ADDR_W-STR_W){stride_q[STR_W-1]}}, stride_q};

  logic [ADDR_W-1:0] ad [LANES];
  logic [EL_W-1:0]   el [LANES];
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ADDR_W-1:0] off;
    assign el[k]  = first + (EL_W'(k) << (S_W'(MAX_S) - pow_q));
    assign off    = ADDR_W'(el[k]) * stride_x;
    assign ad[k]  = base_q + (off << 3);
    assign lane_addr[k*ADDR_W +: ADDR_W] = ad[k];
    assign lane_elem[k*EL_W +: EL_W]     = el[k];
    assign lane_en[k] = {1'b0, el[k]} < vlen_q;
  end

  logic [LANES-1:0] bank_hit;
  always_comb begin
    bank_hit = '0;
    for (int k = 0; k < LANES; k++)
      bank_hit[ad[k][LINE_LG +: BANK_W]] = 1'b1;
  end

  // R4
  bank_uniq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slice_vld |-> (&bank_hit));

  // R2
  slice_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slice_vld && !done) |=> (slice_vld && slice_idx == $past(slice_idx) + SL_W'(1)));

  // R9
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !slice_vld);

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!slice_vld && $past(start)));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slice_vld && start) |=> !err);
endmodule

// File: tb/strided_slice_agen_tb.sv
module strided_slice_agen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 40;
  localparam int SW = 20;
  localparam int LN = 16;
  localparam int EW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] base = '0;
  logic [SW-1:0] stride = '0;
  logic [EW:0] vlen = '0;
  logic busy, slice_vld, done, err;
  logic [2:0] slice_idx;
  logic [LN*AW-1:0] lane_addr;
  logic [LN*EW-1:0] lane_elem;
  logic [LN-1:0] lane_en;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strided_slice_agen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
    .vlen(vlen), .busy(busy), .slice_vld(slice_vld), .slice_idx(slice_idx),
    .done(done), .err(err), .lane_addr(lane_addr), .lane_elem(lane_elem),
    .lane_en(lane_en)
  );

  // base, stride, vlen, expect refusal
  localparam logic [68:0] VEC [13] = '{
    {40'h0000001000, 20'h00001, 8'd128, 1'b0},
    {40'h0000001238, 20'h00003, 8'd100, 1'b0},
    {40'h8000000000, 20'hFFFFB, 8'd128, 1'b0},
    {40'h0000400040, 20'h00002, 8'd37,  1'b0},
    {40'h00000ABC08, 20'h0000C, 8'd128, 1'b0},
    {40'h0000002000, 20'h00008, 8'd65,  1'b0},
    {40'h0000100000, 20'hFFFE8, 8'd200, 1'b0},
    {40'h0000001000, 20'h00010, 8'd128, 1'b1},
    {40'h0000001000, 20'h00000, 8'd128, 1'b1},
    {40'h0000300000, 20'h00006, 8'd0,   1'b0},
    {40'h0000000100, 20'h00028, 8'd1,   1'b0},
    {40'h0000001000, 20'hFFFE0, 8'd64,  1'b1},
    {40'hFFFFFFFF00, 20'h00001, 8'd128, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_req(input logic [AW-1:0] b, input logic [SW-1:0] st,
                         input logic [EW:0] vl, input bit bad, input bit poke);
    logic [127:0] seen;
    longint sv;
    seen = '0;
    sv = longint'($signed(st));
    @(negedge clk);
    base = b; stride = st; vlen = vl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (bad) begin
      chk(err == 1'b1, "R7", "err pulse", err, 1);
      chk(slice_vld == 1'b0, "R7", "no slice", slice_vld, 0);
      @(negedge clk);
      chk(err == 1'b0, "R7", "err one cycle", err, 0);
      chk(slice_vld == 1'b0, "R7", "still no slice", slice_vld, 0);
      return;
    end
    chk(err == 1'b0, "R7", "no err on good stride", err, 0);
    for (int t = 0; t < 8; t++) begin
      logic [15:0] bmask;
      int prev;
      bmask = '0;
      prev = -1;
      chk(slice_vld == 1'b1, "R2", "slice_vld", slice_vld, 1);
      chk(slice_idx == 3'(t), "R2", "slice_idx", slice_idx, t);
      chk(done == (t == 7), "R9", "done", done, (t == 7));
      for (int k = 0; k < LN; k++) begin
        int e;
        logic [AW-1:0] a, ea;
        e  = int'(lane_elem[k*EW +: EW]);
        a  = lane_addr[k*AW +: AW];
        ea = AW'(longint'(b) + longint'(e) * sv * 8);
        chk(a == ea, "R3", "lane address", a, ea);
        chk(lane_en[k] == (e < int'(vl)), "R6", "lane_en", lane_en[k], (e < int'(vl)));
        chk(!seen[e], "R5", "duplicate element", e, -1);
        seen[e] = 1'b1;
        chk(e > prev, "R10", "ascending lanes", e, prev + 1);
        prev = e;
        bmask[a[9:6]] = 1'b1;
      end
      chk(&bmask, "R4", "distinct banks", bmask, 16'hFFFF);
      if (poke && (t == 3 || t == 7)) begin
        base = ~b; stride = 20'h00001; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
    end
    chk(slice_vld == 1'b0, poke ? "R8" : "R2", "no ninth slice", slice_vld, 0);
    chk(err == 1'b0, "R8", "no err after run", err, 0);
    chk(&seen, "R5", "all elements covered", longint'($countones(seen)), 128);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(slice_vld == 1'b0, "R1", "slice_vld", slice_vld, 0);
    chk(done == 1'b0, "R1", "done", done, 0);
    chk(err == 1'b0, "R1", "err", err, 0);

    for (int i = 0; i < 13; i++)
      run_req(VEC[i][68:29], VEC[i][28:9], VEC[i][8:1], VEC[i][0], 1'b0);

    // R8: start pulses during slice 3 and slice 7 of a running request
    run_req(40'h0000005000, 20'h00005, 8'd128, 1'b0, 1'b1);
    run_req(40'h0000006000, 20'h00004, 8'd20, 1'b0, 1'b1);

    // R6: vlen of zero still runs the full eight slices
    run_req(40'h0000000000, 20'h00001, 8'd0, 1'b0, 1'b0);

    // R1: reset in the middle of a run returns to idle
    @(negedge clk);
    base = 40'h1000; stride = 20'h1; vlen = 8'd128; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(busy == 1'b0, "R1", "busy after mid-run reset", busy, 0);
    chk(slice_vld == 1'b0, "R1", "slice_vld after mid-run reset", slice_vld, 0);

    run_req(40'h0000007000, 20'h00007, 8'd128, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule